// File: doc/BRIEF.md
# Phase Transient Corrector with Virtual Reference

This block sits in front of the phase detector of a digital PLL. It removes the phase step the loop would otherwise see when the active reference input changes, or when the loop comes out of holdover. When such an event occurs, the block measures how far the feedback edge trails the reference edge, counted in master clock cycles, and stores that offset. It then emits a virtual reference pulse that trails every reference edge by the stored offset. The phase detector compares this pulse against feedback, so the error it sees at the event is close to zero.

A reference switch always starts a correction. A holdover exit starts one only when the enable input is high. Between events the stored offset stays unchanged. While a new offset is being measured, the old one stays in use, so the virtual pulse stream continues without a gap. When the selected reference is reported lost, the virtual pulse is withheld.

Top module: `phase_hit_corrector`

## Requirements
- R1: After reset `vref_pulse` and `measuring` are low and the stored offset is 0, so each reference edge yields a virtual pulse one cycle later.
- R2: A `ref_switch` pulse starts a measurement: `measuring` is high from the cycle after the pulse.
- R3: A `hold_exit` pulse starts a measurement only while `hold_exit_en` is high; with the enable low it changes neither `measuring` nor the stored offset.
- R4: A measurement uses the first `ref_edge` after the trigger and stores the number of cycles from that edge to the first following `fb_edge`. An `fb_edge` in the same cycle as that reference edge stores 0.
- R5: The cycle after the `fb_edge` that ends a measurement, `measuring` is low.
- R6: If no `fb_edge` arrives within `MAX_PERIOD` cycles of the measured reference edge, the measurement is abandoned, the previous offset is kept, and `measuring` goes low `MAX_PERIOD`+1 cycles after that edge.
- R7: For a reference edge in cycle t and a stored offset D, `vref_pulse` is high for exactly one cycle, in cycle t+D+1.
- R8: During a measurement, the previous offset delays every reference edge, including the edge being measured. The new offset applies from the first reference edge after it is stored.
- R9: While `ref_lost` is high, `vref_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle pulse on each selected-reference edge |
| fb_edge | input | 1 | One-cycle pulse on each feedback edge |
| ref_switch | input | 1 | Pulse: the selected reference has changed |
| hold_exit | input | 1 | Pulse: the loop has left holdover |
| hold_exit_en | input | 1 | Allows `hold_exit` to start a correction |
| ref_lost | input | 1 | Selected reference is currently failed |
| vref_pulse | output | 1 | Virtual reference pulse for the phase detector |
| measuring | output | 1 | High from a trigger until the offset is stored or abandoned |

## Verification
A wrong stored offset shows directly at the ports: the first virtual pulse after the measurement lands in the wrong cycle, within one reference period of the latching feedback edge. A stuck or wrong measurement state shows as `measuring` failing to rise in the cycle after a trigger, or failing to fall the cycle after the feedback edge or the timeout. A delay counter that loses or adds a count either moves every pulse by a fixed amount or drops pulses. The scoreboard catches both on the very next reference edge.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_ARM   = 2'd1,
      MS_COUNT = 2'd2
   } meas_st_e;
endpackage

// File: rtl/ptc_event_gate.sv
module ptc_event_gate (
   input  logic ref_switch,
   input  logic hold_exit,
   input  logic hold_exit_en,
   output logic trig
);
   // a switch always restarts correction; holdover exit only when allowed
   assign trig = ref_switch | (hold_exit & hold_exit_en);
endmodule

// File: rtl/ptc_phase_meter.sv
module ptc_phase_meter
   import ptc_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int MAX_PERIOD = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             ref_edge,
   input  logic             fb_edge,
   output logic [CNT_W-1:0] offset,
   output logic             measuring
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PERIOD);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   meas_st_e         st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= MS_IDLE;
         cnt    <= '0;
         offset <= '0;
      end else if (trig) begin
         st  <= MS_ARM;
         cnt <= '0;
      end else begin
         unique case (st)
            MS_ARM: begin
               if (ref_edge) begin
                  if (fb_edge) begin
                     offset <= '0;
                     st     <= MS_IDLE;
                  end else begin
                     cnt <= ONE;
                     st  <= MS_COUNT;
                  end
               end
            end
            MS_COUNT: begin
               if (fb_edge) begin
                  offset <= cnt;
                  st     <= MS_IDLE;
               end else if (cnt == LIMIT) begin
                  st <= MS_IDLE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            default: st <= MS_IDLE;
         endcase
      end
   end

   assign measuring = (st != MS_IDLE);
endmodule

// File: rtl/ptc_vref_gen.sv
module ptc_vref_gen #(
   parameter int CNT_W            = 8,
   parameter bit LOST_CLEARS_PEND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_edge,
   input  logic             ref_lost,
   input  logic [CNT_W-1:0] offset,
   output logic             vref_pulse
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             pend;
   logic [CNT_W-1:0] dcnt;
   logic             fire;
   logic             cancel;

   generate
      if (LOST_CLEARS_PEND) begin : g_cancel
         assign cancel = ref_lost;
      end else begin : g_keep
         assign cancel = 1'b0;
      end
   endgenerate

   assign fire = ref_edge ? (offset == '0) : (pend && dcnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         dcnt       <= '0;
         vref_pulse <= 1'b0;
      end else begin
         vref_pulse <= fire & ~ref_lost;
         if (cancel) begin
            pend <= 1'b0;
         end else if (ref_edge) begin
            dcnt <= offset;
            pend <= (offset != '0);
         end else if (pend) begin
            dcnt <= dcnt - ONE;
            if (dcnt == ONE) pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/phase_hit_corrector.sv
module phase_hit_corrector #(
   parameter int CNT_W            = 8,
   parameter int MAX_PERIOD       = 200,
   parameter bit LOST_CLEARS_PEND = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_edge,
   input  logic fb_edge,
   input  logic ref_switch,
   input  logic hold_exit,
   input  logic hold_exit_en,
   input  logic ref_lost,
   output logic vref_pulse,
   output logic measuring
);
   generate
      if (CNT_W < 2 || MAX_PERIOD < 2 || MAX_PERIOD >= (2 ** CNT_W)) begin : g_bad_cfg
         $error("phase_hit_corrector: MAX_PERIOD must be in 2 .. 2**CNT_W-1");
      end
   endgenerate

   logic             trig;
   logic [CNT_W-1:0] offset;

   ptc_event_gate i_gate (
      .ref_switch  (ref_switch),
      .hold_exit   (hold_exit),
      .hold_exit_en(hold_exit_en),
      .trig        (trig)
   );

   ptc_phase_meter #(.CNT_W(CNT_W), .MAX_PERIOD(MAX_PERIOD)) i_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .ref_edge (ref_edge),
      .fb_edge  (fb_edge),
      .offset   (offset),
      .measuring(measuring)
   );

   ptc_vref_gen #(.CNT_W(CNT_W), .LOST_CLEARS_PEND(LOST_CLEARS_PEND)) i_vgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_edge  (ref_edge),
      .ref_lost  (ref_lost),
      .offset    (offset),
      .vref_pulse(vref_pulse)
   );
endmodule

// File: rtl/phase_hit_corrector_chk.sv
module phase_hit_corrector_chk #(
   parameter int CNT_W      = 8,
   parameter int MAX_PERIOD = 200
) (
   input logic clk,
   input logic rst_n,
   input logic ref_edge,
   input logic ref_switch,
   input logic hold_exit,
   input logic hold_exit_en,
   input logic ref_lost,
   input logic vref_pulse,
   input logic measuring
);
   localparam int SW = CNT_W + 1;
   localparam logic [SW-1:0] SAT  = '1;
   localparam logic [SW-1:0] SPAN = SW'(MAX_PERIOD + 1);

   logic [SW-1:0] since_ref;

   always_ff @(posedge clk) begin
      if (!rst_n)               since_ref <= SAT;
      else if (ref_edge)        since_ref <= SW'(1);
      else if (since_ref != SAT) since_ref <= since_ref + SW'(1);
   end

   AST_SWITCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_switch |=> measuring); // R2
   AST_HOLD_ENABLED_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_exit && hold_exit_en) |=> measuring); // R3
   AST_QUIET_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!measuring && !ref_switch && !(hold_exit && hold_exit_en)) |=> !measuring); // R3
   AST_LOST_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
      ref_lost |=> !vref_pulse); // R9
   AST_PULSE_NEAR_REF: assert property (@(posedge clk) disable iff (!rst_n)
      vref_pulse |-> (since_ref <= SPAN)); // R7
endmodule

bind phase_hit_corrector phase_hit_corrector_chk #(
   .CNT_W(CNT_W), .MAX_PERIOD(MAX_PERIOD)
) i_chk (
   .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .ref_switch(ref_switch),
   .hold_exit(hold_exit), .hold_exit_en(hold_exit_en), .ref_lost(ref_lost),
   .vref_pulse(vref_pulse), .measuring(measuring)
);

// File: tb/test_phase_hit_corrector.sv
module test_phase_hit_corrector;
   localparam int MAXP = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_edge = 1'b0, fb_edge = 1'b0, ref_switch = 1'b0;
   logic hold_exit = 1'b0, hold_exit_en = 1'b0, ref_lost = 1'b0;
   logic vref_pulse, measuring;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;
   int   exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   phase_hit_corrector #(.CNT_W(8), .MAX_PERIOD(MAXP)) i_phase_hit_corrector (
      .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
      .ref_switch(ref_switch), .hold_exit(hold_exit), .hold_exit_en(hold_exit_en),
      .ref_lost(ref_lost), .vref_pulse(vref_pulse), .measuring(measuring)
   );

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // monitor: pops expected pulse cycles and compares
   always @(negedge clk) begin
      if (mon_on) begin
         if (exp_q.size() > 0 && exp_q[0] < cyc) begin
            check(1'b0, tag_q[0], -1, exp_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
         if (vref_pulse) begin
            if (exp_q.size() == 0) check(1'b0, "R9/R7 unexpected pulse", cyc, -1);
            else begin
               check(exp_q[0] == cyc, tag_q[0], cyc, exp_q[0]);
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
         end
      end
   end

   // one trigger cycle; the next cycle's measuring value is checked
   task automatic trigger(bit sw, bit hx, bit en, bit exp_meas, string req);
      @(negedge clk);
      ref_switch = sw; hold_exit = hx; hold_exit_en = en;
      @(negedge clk);
      ref_switch = 1'b0; hold_exit = 1'b0; hold_exit_en = 1'b0;
      check(measuring == exp_meas, req, measuring, exp_meas);
   endtask

   // driver: reference edges every period, feedback d cycles later
   task automatic burst(int period, int d, int n, bit fb_on, bit lost,
                        int off_first, int off_rest, string req,
                        int probe_k, bit probe_v, string preq);
      for (int k = 0; k < n * period; k++) begin
         @(negedge clk);
         if (k == probe_k) check(measuring == probe_v, preq, measuring, probe_v);
         ref_edge = (k % period == 0);
         fb_edge  = fb_on && (k >= d) && ((k - d) % period == 0);
         ref_lost = lost;
         if (ref_edge && !lost) begin
            exp_q.push_back(cyc + ((k == 0) ? off_first : off_rest) + 1);
            tag_q.push_back(req);
         end
      end
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0; ref_lost = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(vref_pulse == 1'b0, "R1 vref after reset", vref_pulse, 0);
      check(measuring == 1'b0, "R1 measuring after reset", measuring, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      // R1 / R7: zero offset from reset
      burst(20, 0, 3, 1'b0, 1'b0, 0, 0, "R1 R7 zero offset", -1, 1'b0, "");
      // R2 R4 R8: switch, feedback 5 cycles late
      trigger(1'b1, 1'b0, 1'b0, 1'b1, "R2 measuring after switch");
      burst(25, 5, 3, 1'b1, 1'b0, 0, 5, "R4 R8 offset 5", 6, 1'b0, "R5 measuring low");
      // R3: holdover exit with enable low changes nothing
      trigger(1'b0, 1'b1, 1'b0, 1'b0, "R3 disabled exit");
      burst(25, 12, 3, 1'b1, 1'b0, 5, 5, "R3 offset kept", -1, 1'b0, "");
      // R3: holdover exit with enable high, feedback 9 late
      trigger(1'b0, 1'b1, 1'b1, 1'b1, "R3 enabled exit");
      burst(25, 9, 3, 1'b1, 1'b0, 5, 9, "R8 offset 9", 9, 1'b1, "R5 measuring at fb");
      // R6: no feedback, timeout keeps offset 9
      trigger(1'b1, 1'b0, 1'b0, 1'b1, "R2 second switch");
      burst(30, 0, 3, 1'b0, 1'b0, 9, 9, "R6 offset kept", MAXP + 1, 1'b0, "R6 timeout");
      // R4: feedback in the same cycle as reference
      trigger(1'b1, 1'b0, 1'b0, 1'b1, "R2 third switch");
      burst(20, 0, 3, 1'b1, 1'b0, 9, 0, "R4 coincident offset 0", 1, 1'b0, "R5 coincident");
      // R9: reference lost suppresses pulses
      burst(20, 0, 3, 1'b0, 1'b1, 0, 0, "R9", -1, 1'b0, "");
      burst(20, 0, 2, 1'b0, 1'b0, 0, 0, "R9 R7 resumed", -1, 1'b0, "");
      // R8 large offset near the period
      trigger(1'b1, 1'b0, 1'b0, 1'b1, "R2 fourth switch");
      burst(20, 17, 3, 1'b1, 1'b0, 0, 17, "R8 offset 17", -1, 1'b0, "");
      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R7 missing pulses", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule